// File: doc/BRIEF.md
# Two-Bank Mixed-Trigger Interrupt Controller

This block gathers 64 interrupt request lines into two 32-bit banks and drives a single interrupt line to one CPU. Each bank keeps four words of state. An event word latches edge-style requests. A mask word enables sources. A level word mirrors the present state of the inputs. A fixed level-flag word marks which sources are level-style. A level-style source never latches an event. It requests service only while its input stays high, so an acknowledge cannot clear it. An edge-style source latches an event on its rising edge, and that event stays set until software acknowledges it.

Software uses a plain synchronous 32-bit register port with a 12-bit address, which covers a 4 KiB window. Write data and read data are little-endian words taken bit for bit. Mask writes and acknowledges are the only stores. Reads are combinational from the current state. The interrupt inputs are sampled on the bus clock. The CPU line is registered, so it follows the new state at the same edge that loads any input change or write.

Top module: `mtic_top`

## Requirements
- R1: After reset, `irq_out` is low and every event, mask and level word reads as zero. Bank 0 has no level-style sources. In bank 1, only bits 20 to 28 are level-style.
- R2: Input k maps to bank 1 − (k / 32), bit k mod 32. Inputs 0–31 therefore land in bank 1 and inputs 32–63 in bank 0.
- R3: On the clock edge where an input goes from low to high, its level bit becomes 1. If the source is edge-style, its event bit is also set.
- R4: When an input falls, only its level bit clears. An event bit that was latched stays set.
- R5: A write to bank offset 0x8 clears the event bits at the positions written as 1. Bits flagged level-style are left alone.
- R6: A write to bank offset 0x4 replaces that bank's mask with the written word.
- R7: A bank is pending when (events | (levels & level_flags)) & mask is nonzero. `irq_out` is high exactly when either bank is pending, and it reflects state one edge after the change that caused it.
- R8: A level-style source never sets its event bit. It raises `irq_out` while its input is high and unmasked, and it drops `irq_out` when its input falls, with no acknowledge needed.
- R9: The bank index is ((addr − 0x10) mod 4096) >> 4, so bank 0 sits at 0x10 and bank 1 at 0x20. A write whose index is 2 or more changes nothing. A write to offset 0x0 or 0xC also changes nothing.
- R10: If an input rises in the same cycle as an acknowledge of its event bit, the event bit ends up set.
- R11: Offsets 0x0 and 0x8 both read the event word, 0x4 reads the mask and 0xC reads the level word. Any other offset, or any index of 2 or more, reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request levels, synchronous to clk |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address in the 4 KiB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Registered CPU interrupt request |

## Verification
Directed cases separate the two halves of the input numbering by raising one source on each side and reading back which bank latched it. They contrast an edge-style source with a level-style one in bank 1 under the same mask, acknowledge and fall sequence. One case lines up a rising edge with an acknowledge of the same bit, to show which action wins. Writes to out-of-range indices, to the address range that wraps below 0x10 and to the read-only offsets show that stores are ignored there. A long stretch of random input words mixed with random writes is then checked against a behavioural model on every clock, with periodic read-back of all six state words.

// File: rtl/mtic_pkg.sv
package mtic_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] BANK_BASE = 12'h010;
  localparam int unsigned BANK_STRIDE_LG = 4;

  localparam logic [3:0] OFS_EVT  = 4'h0;
  localparam logic [3:0] OFS_MASK = 4'h4;
  localparam logic [3:0] OFS_ACK  = 4'h8;
  localparam logic [3:0] OFS_LVL  = 4'hC;
endpackage

// File: rtl/mtic_inmap.sv
module mtic_inmap #(
  parameter int unsigned NB = 2,
  parameter int unsigned W  = 32
) (
  input  logic [NB*W-1:0]       irq_in,
  output logic [NB-1:0][W-1:0]  bank_src
);
  // Lowest input segment feeds the highest bank.
  for (genvar b = 0; b < NB; b++) begin : g_map
    assign bank_src[b] = irq_in[(NB-1-b)*W +: W];
  end
endmodule

// File: rtl/mtic_bank.sv
module mtic_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] LT_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         mask_we,
  input  logic         ack_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ev_q,
  output logic [W-1:0] mk_q,
  output logic [W-1:0] lv_q,
  output logic [W-1:0] lt_q,
  output logic         pend_nxt
);
  logic [W-1:0] rise;
  logic [W-1:0] clr;
  logic [W-1:0] ev_nxt;
  logic [W-1:0] mk_nxt;

  assign lt_q   = LT_INIT;
  assign rise   = src & ~lv_q;
  assign clr    = ack_we ? (wdata & ~lt_q) : '0;
  assign ev_nxt = (ev_q & ~clr) | (rise & ~lt_q);
  assign mk_nxt = mask_we ? wdata : mk_q;
  assign pend_nxt = |((ev_nxt | (src & lt_q)) & mk_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      mk_q <= '0;
      lv_q <= '0;
    end else begin
      ev_q <= ev_nxt;
      mk_q <= mk_nxt;
      lv_q <= src;
    end
  end
endmodule

// File: rtl/mtic_regif.sv
module mtic_regif
  import mtic_pkg::*;
#(
  parameter int unsigned NB = 2,
  parameter int unsigned W  = 32
) (
  input  logic                  reg_wen,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [NB-1:0][W-1:0]  ev_all,
  input  logic [NB-1:0][W-1:0]  mk_all,
  input  logic [NB-1:0][W-1:0]  lv_all,
  output logic [NB-1:0]         mask_we,
  output logic [NB-1:0]         ack_we,
  output logic [W-1:0]          reg_rdata
);
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] idx;
  logic [3:0]        ofs;
  logic [NB-1:0]     sel;

  assign rel = reg_addr - BANK_BASE;
  assign idx = rel >> BANK_STRIDE_LG;
  assign ofs = reg_addr[3:0];

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign sel[b]     = (idx == ADDR_W'(b));
    assign mask_we[b] = reg_wen && sel[b] && (ofs == OFS_MASK);
    assign ack_we[b]  = reg_wen && sel[b] && (ofs == OFS_ACK);
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (sel[b]) begin
        unique case (ofs)
          OFS_EVT, OFS_ACK: reg_rdata = reg_rdata | ev_all[b];
          OFS_MASK:         reg_rdata = reg_rdata | mk_all[b];
          OFS_LVL:          reg_rdata = reg_rdata | lv_all[b];
          default:          reg_rdata = reg_rdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/mtic_top.sv
module mtic_top
  import mtic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter logic [NUM_BANKS-1:0][BANK_W-1:0] LT_INIT = {32'h1FF0_0000, 32'h0000_0000},
  localparam int unsigned NUM_IN   = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_src;
  logic [NUM_BANKS-1:0][BANK_W-1:0] ev_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0] mk_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0] lv_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0] lt_q;
  logic [NUM_BANKS-1:0]             mask_we;
  logic [NUM_BANKS-1:0]             ack_we;
  logic [NUM_BANKS-1:0]             pend_nxt;
  logic                             irq_q;

  mtic_inmap #(.NB(NUM_BANKS), .W(BANK_W)) u_inmap (
    .irq_in   (irq_in),
    .bank_src (bank_src)
  );

  mtic_regif #(.NB(NUM_BANKS), .W(BANK_W)) u_regif (
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .ev_all    (ev_q),
    .mk_all    (mk_q),
    .lv_all    (lv_q),
    .mask_we   (mask_we),
    .ack_we    (ack_we),
    .reg_rdata (reg_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    mtic_bank #(.W(BANK_W), .LT_INIT(LT_INIT[b])) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (bank_src[b]),
      .mask_we  (mask_we[b]),
      .ack_we   (ack_we[b]),
      .wdata    (reg_wdata),
      .ev_q     (ev_q[b]),
      .mk_q     (mk_q[b]),
      .lv_q     (lv_q[b]),
      .lt_q     (lt_q[b]),
      .pend_nxt (pend_nxt[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend_nxt;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/mtic_chk.sv
module mtic_chk
  import mtic_pkg::*;
#(
  parameter int unsigned NB = 2,
  parameter int unsigned W  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NB*W-1:0]      irq_in,
  input logic                 reg_wen,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [W-1:0]         reg_wdata,
  input logic                 irq_out,
  input logic [NB-1:0][W-1:0] ev_q,
  input logic [NB-1:0][W-1:0] mk_q,
  input logic [NB-1:0][W-1:0] lv_q,
  input logic [NB-1:0][W-1:0] lt_q
);
  logic [ADDR_W-1:0] c_idx;
  logic [NB-1:0]     c_ack;
  logic [NB-1:0]     c_msk;
  logic              c_pend;

  assign c_idx = (reg_addr - 12'h010) >> 4;

  always_comb begin
    c_pend = 1'b0;
    for (int b = 0; b < NB; b++)
      c_pend = c_pend | (((ev_q[b] | (lv_q[b] & lt_q[b])) & mk_q[b]) != '0);
  end

  AST_IRQ_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == c_pend); // R7

  for (genvar b = 0; b < NB; b++) begin : g_b
    assign c_ack[b] = reg_wen && (c_idx == ADDR_W'(b)) && (reg_addr[3:0] == 4'h8);
    assign c_msk[b] = reg_wen && (c_idx == ADDR_W'(b)) && (reg_addr[3:0] == 4'h4);

    AST_LEVEL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> lv_q[b] == $past(irq_in[(NB-1-b)*W +: W])); // R3

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(c_ack[b])) |-> ((ev_q[b] & $past(ev_q[b])) == $past(ev_q[b]))); // R4

    AST_LEVEL_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q[b] & lt_q[b]) == '0); // R8

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      c_msk[b] |=> mk_q[b] == $past(reg_wdata)); // R6
  end
endmodule

bind mtic_top mtic_chk #(.NB(NUM_BANKS), .W(BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_in    (irq_in),
  .reg_wen   (reg_wen),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_out   (irq_out),
  .ev_q      (ev_q),
  .mk_q      (mk_q),
  .lv_q      (lv_q),
  .lt_q      (lt_q)
);

// File: tb/mtic_top_tb.sv
`timescale 1ns/1ps
module mtic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  mtic_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  initial forever #10 clk = ~clk;

  // Behavioural reference model
  bit [31:0] m_ev [2];
  bit [31:0] m_mk [2];
  bit [31:0] m_lv [2];
  bit [31:0] m_lt [2] = '{32'h0, 32'h1FF0_0000};
  bit        m_irq;

  function automatic int bank_of(int a);
    return (((a - 16) & 12'hFFF) >> 4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin m_ev[b] = 0; m_mk[b] = 0; m_lv[b] = 0; end
      m_irq = 0;
    end else begin
      int bi;
      int ofs;
      bi = bank_of(reg_addr);
      ofs = reg_addr & 15;
      if (reg_wen && bi < 2 && ofs == 8) m_ev[bi] = m_ev[bi] & ~(reg_wdata & ~m_lt[bi]);
      if (reg_wen && bi < 2 && ofs == 4) m_mk[bi] = reg_wdata;
      for (int k = 0; k < 64; k++) begin
        int b;
        int t;
        b = 1 - k / 32;
        t = k % 32;
        if (irq_in[k] && !m_lv[b][t] && !m_lt[b][t]) m_ev[b][t] = 1'b1;
      end
      for (int k = 0; k < 64; k++) m_lv[1 - k / 32][k % 32] = irq_in[k];
      m_irq = 0;
      for (int b = 0; b < 2; b++)
        if (((m_ev[b] | (m_lv[b] & m_lt[b])) & m_mk[b]) != 0) m_irq = 1;
    end
  end

  function automatic bit [31:0] exp_rd(int a);
    int bi;
    int o;
    bi = bank_of(a);
    o = a & 15;
    if (bi >= 2) return 0;
    case (o)
      0, 8: return m_ev[bi];
      4:    return m_mk[bi];
      12:   return m_lv[bi];
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every-cycle comparison of the CPU line (R7)
  always @(negedge clk) if (rst_n && !done) chk(irq_out == m_irq, "R7 irq_out", {31'b0, irq_out}, {31'b0, m_irq});

  task automatic step(); @(negedge clk); endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wen = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wen = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, req, reg_rdata, exp);
    chk(reg_rdata === exp_rd(a), {req, " model"}, reg_rdata, exp_rd(a));
  endtask

  task automatic lvl(logic [31:0] exp, string req);
    #1;
    chk(irq_out === exp[0], req, {31'b0, irq_out}, exp);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R1 reset state
    rd(12'h010, 0, "R1 bank0 events"); rd(12'h014, 0, "R1 bank0 mask");
    rd(12'h01C, 0, "R1 bank0 levels"); rd(12'h020, 0, "R1 bank1 events");
    rd(12'h024, 0, "R1 bank1 mask"); rd(12'h02C, 0, "R1 bank1 levels");
    lvl(0, "R1 irq low");
    // R2/R3 input 35 -> bank0 bit3
    irq_in[35] = 1; step();
    rd(12'h010, 32'h8, "R2 R3 bank0 event"); rd(12'h01C, 32'h8, "R3 bank0 level");
    rd(12'h020, 0, "R2 bank1 untouched");
    lvl(0, "R7 masked off");
    wr(12'h014, 32'h8);
    rd(12'h014, 32'h8, "R6 mask load"); lvl(1, "R7 pending");
    // R4 fall keeps event
    irq_in[35] = 0; step();
    rd(12'h01C, 0, "R4 level cleared"); rd(12'h010, 32'h8, "R4 event kept");
    lvl(1, "R4 irq held");
    // R5 acknowledge
    wr(12'h018, 32'h8);
    rd(12'h010, 0, "R5 ack cleared"); lvl(0, "R5 irq dropped");
    // R8 level-style source input 20 -> bank1 bit20
    wr(12'h024, 32'h0010_0000);
    irq_in[20] = 1; step();
    rd(12'h020, 0, "R8 no event"); rd(12'h02C, 32'h0010_0000, "R2 bank1 level");
    lvl(1, "R8 irq high");
    wr(12'h028, 32'h0010_0000);
    lvl(1, "R5 R8 ack ignored");
    irq_in[20] = 0; step();
    lvl(0, "R8 irq falls with input");
    // R1 bank0 has no level-style bits: input 52 -> bank0 bit20 latches
    irq_in[52] = 1; step();
    rd(12'h010, 32'h0010_0000, "R1 bank0 bit20 edge-style");
    irq_in[52] = 0; wr(12'h018, 32'hFFFF_FFFF);
    // R10 rise with same-cycle ack, input 5 -> bank1 bit5
    irq_in[5] = 1; wr(12'h028, 32'h20);
    rd(12'h020, 32'h20, "R10 set wins");
    irq_in[5] = 0; wr(12'h028, 32'h20);
    rd(12'h020, 0, "R5 bank1 ack");
    // R9 ignored writes
    wr(12'h034, 32'hFFFF_FFFF); wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF); wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h014, 32'h8, "R9 bank0 mask unchanged");
    rd(12'h024, 32'h0010_0000, "R9 bank1 mask unchanged");
    rd(12'h010, 0, "R9 bank0 events unchanged");
    // R11 read map
    irq_in[33] = 1; step();
    rd(12'h018, 32'h2, "R11 offset8 reads events");
    rd(12'h034, 0, "R11 index2 reads zero");
    rd(12'h000, 0, "R11 wrapped index reads zero");
    rd(12'h012, 0, "R11 odd offset reads zero");
    irq_in[33] = 0; wr(12'h018, 32'h2);
    // Random phase: model compared every clock
    for (int i = 0; i < 600; i++) begin
      irq_in = {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom % 3 == 0) begin
        logic [11:0] a;
        case ($urandom % 6)
          0: a = 12'h014; 1: a = 12'h018; 2: a = 12'h024;
          3: a = 12'h028; 4: a = 12'h034; default: a = 12'h00C;
        endcase
        reg_wen = 1; reg_addr = a; reg_wdata = $urandom;
      end else reg_wen = 0;
      step();
      reg_wen = 0;
      if (i % 16 == 15) begin
        for (int b = 0; b < 2; b++)
          for (int o = 0; o < 16; o += 4) begin
            logic [11:0] a;
            a = 12'(16 + 16 * b + o);
            rd(a, exp_rd(a), "R3 R4 R5 R6 R11 random read");
          end
      end
    end
    step();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule